// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a 24-bit system tick timer. Software sets a reload value, enables the counter and picks a tick source. On every tick the count steps down by one. When it steps from one to zero, a sticky count flag is set and, if interrupts are enabled, a single-cycle interrupt request pulse goes out. On the tick after it reaches zero the count reloads, so the timer produces one event every reload-plus-one ticks.

The tick source is either every core clock or a one-cycle enable that occurs on every eighth core clock. The whole block stays in the core clock domain. A debug-halt input freezes the count. A software-pend input raises the interrupt request without any counter event.

Software reaches the timer through a small register port. Writes take effect at the clock edge. Read data is combinational from the register state.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current registers read as zero and `irq` is low. The current value changes on a tick only while the enable bit is set. With the enable bit clear, the current value holds.
- R2: A tick that moves the count from 1 to 0 sets the count flag. When the interrupt-enable bit is set, the same tick also makes `irq` high for exactly one cycle, on the cycle after the tick edge. When the interrupt-enable bit is clear, `irq` stays low and the flag is still set.
- R3: A tick that finds the count at zero loads the reload value. Events therefore repeat every reload+1 ticks.
- R4: Any write to the current-value register, whatever its data, sets the count to the reload value and clears the count flag. This holds whether or not the timer is enabled or halted.
- R5: When the source-select bit is 1, every core clock is a tick. When it is 0, a tick occurs once every eighth core clock, so the event period becomes 8*(reload+1) clocks.
- R6: While `dbg_halt` is high, the count does not change, except through a write to the current-value register.
- R7: A high `sw_pend` makes `irq` high on the following cycle, whatever the enable bits are.
- R8: With a reload value of zero, the count stays at zero once it gets there, and neither the flag nor `irq` is raised.
- R9: A read of the control register clears the count flag. If a 1-to-0 event occurs in the same cycle as the read, the flag stays set.
- R10: The register map is as follows:
  - Address 0 is control/status. Bit 0 is enable, bit 1 is interrupt-enable, bit 2 is source-select and bit 16 is the count flag (read only).
  - Address 1 is the reload value, in bits 23:0.
  - Address 2 is the current value, in bits 23:0.
  - Address 3 reads as zero.
  - All bits not named above read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (used for the flag clear) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| dbg_halt | input | 1 | Freezes the count while high |
| sw_pend | input | 1 | Software interrupt pend |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench measures the spacing between `irq` pulses for several reload values under both tick sources, including a reload of one. A design that flagged on reaching zero instead of on leaving one, or that reloaded in the same tick as the event, would show a period one tick too short. A design whose divided tick was gated wrongly would show a period that is not a multiple of eight clocks. The bench also covers these cases:
- A reload of zero, where a faulty design would keep firing.
- A write to the current value while the timer is disabled and the flag is set, where a design that only reloaded on a tick or left the flag alone would be caught.
- A frozen count under halt.
- A software pend with interrupts disabled.
- Two back-to-back control reads, the second of which must see the flag cleared.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    localparam int POS_EN   = 0;
    localparam int POS_IE   = 1;
    localparam int POS_SRC  = 2;
    localparam int POS_FLAG = 16;

    typedef struct packed {
        logic en;
        logic ie;
        logic src;
    } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        pulse = (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_pulse_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    input  logic [CNT_W-1:0]  cur,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic [DATA_W-1:0] rdata,
    output logic              cur_wr,
    output logic              ctrl_rd
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;

    logic unused_wdata;
    assign unused_wdata = &{1'b0, wdata[DATA_W-1:CNT_W]};

    always_comb begin
        sel     = reg_sel_e'(addr);
        r_d     = r_q;
        cur_wr  = wr && (sel == SEL_CURRENT);
        ctrl_rd = rd && (sel == SEL_CTRL);
        if (wr && sel == SEL_CTRL) begin
            r_d.ctrl.en  = wdata[POS_EN];
            r_d.ctrl.ie  = wdata[POS_IE];
            r_d.ctrl.src = wdata[POS_SRC];
        end
        if (wr && sel == SEL_RELOAD) r_d.reload = wdata[CNT_W-1:0];

        rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                rdata[POS_EN]   = r_q.ctrl.en;
                rdata[POS_IE]   = r_q.ctrl.ie;
                rdata[POS_SRC]  = r_q.ctrl.src;
                rdata[POS_FLAG] = flag;
            end
            SEL_RELOAD:  rdata[CNT_W-1:0] = r_q.reload;
            SEL_CURRENT: rdata[CNT_W-1:0] = cur;
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl   = r_q.ctrl;
    assign reload = r_q.reload;

    p_reload_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd1) |=> reload == $past(wdata[CNT_W-1:0]));

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cur_wr,
    input  logic             ctrl_rd,
    input  logic             irq_en,
    input  logic             sw_pend,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cur,
    output logic             flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             flag;
        logic             irq;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       expire;

    always_comb begin
        s_d     = s_q;
        s_d.irq = sw_pend;
        expire  = 1'b0;
        if (cur_wr) begin
            s_d.cur  = reload;
            s_d.flag = 1'b0;
        end else if (tick) begin
            if (s_q.cur == '0) begin
                s_d.cur = reload;
            end else begin
                s_d.cur = s_q.cur - ONE;
                expire  = (s_q.cur == ONE);
            end
        end
        if (expire) begin
            s_d.flag = 1'b1;
            if (irq_en) s_d.irq = 1'b1;
        end else if (ctrl_rd) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.cur;
    assign flag = s_q.flag;
    assign irq  = s_q.irq;

    p_reload_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cur_wr && cur == '0) |=> cur == $past(reload));

    p_cur_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cur == $past(reload)) && !flag);

    p_flag_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cur_wr && cur == ONE) |=> flag);

    p_pend_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pend |=> irq);

    p_zero_reload_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_wr && cur == '0 && reload == '0 && !sw_pend) |=> (cur == '0) && !irq);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int DIV    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dbg_halt,
    input  logic              sw_pend,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cur;
    logic             flag;
    logic             cur_wr;
    logic             ctrl_rd;
    logic             slow_pulse;
    logic             tick;

    tick_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (slow_pulse)
    );

    tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .flag    (flag),
        .cur     (cur),
        .ctrl    (ctrl),
        .reload  (reload),
        .rdata   (reg_rdata),
        .cur_wr  (cur_wr),
        .ctrl_rd (ctrl_rd)
    );

    assign tick = ctrl.en && !dbg_halt && (ctrl.src || slow_pulse);

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cur_wr  (cur_wr),
        .ctrl_rd (ctrl_rd),
        .irq_en  (ctrl.ie),
        .sw_pend (sw_pend),
        .reload  (reload),
        .cur     (cur),
        .flag    (flag),
        .irq     (irq)
    );

    p_hold_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !cur_wr) |=> $stable(cur));

    p_halt_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !cur_wr) |=> $stable(cur));

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        dbg_halt;
    logic        sw_pend;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    localparam int NV = 5;
    localparam int TV_RL  [NV] = '{3, 10, 2, 1, 5};
    localparam int TV_SRC [NV] = '{1, 1, 0, 1, 0};
    localparam int TV_PER [NV] = '{4, 11, 24, 2, 48};

    localparam logic [31:0] C_EN  = 32'h1;
    localparam logic [31:0] C_IE  = 32'h2;
    localparam logic [31:0] C_SRC = 32'h4;

    always #2.5 clk = ~clk;

    tick_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dbg_halt  (dbg_halt),
        .sw_pend   (sw_pend),
        .irq       (irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (irq) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        bit seen;
        int cnt;
        int irq_hits;
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_wdata = '0; dbg_halt = 1'b0; sw_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10 reset state
        reg_read(2'd0, v); check("R1 ctrl after reset", v, 0);
        reg_read(2'd1, v); check("R1 reload after reset", v, 0);
        reg_read(2'd2, v); check("R1 current after reset", v, 0);
        check("R1 irq after reset", irq, 0);
        reg_read(2'd3, v); check("R10 unused address", v, 0);

        // R3 R5 R2: table of reload / source / expected period
        for (int k = 0; k < NV; k++) begin
            reg_write(2'd0, 32'h0);
            reg_write(2'd1, 32'(TV_RL[k]));
            reg_write(2'd2, 32'h5A5A5A);
            reg_write(2'd0, C_EN | C_IE | (TV_SRC[k] != 0 ? C_SRC : 32'h0));
            wait_irq(seen);
            check("R2 first irq seen", seen, 1);
            @(negedge clk);
            cnt = 1;
            check("R2 irq one cycle wide", irq, 0);
            while (!irq && cnt < 2000) begin
                @(negedge clk);
                cnt++;
            end
            check($sformatf("R3 R5 period vector %0d", k), cnt, TV_PER[k]);
        end

        // R1 disabled hold, then counting
        reg_write(2'd0, 32'h0);
        reg_write(2'd1, 32'd100);
        reg_write(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        reg_read(2'd2, v); check("R1 disabled holds", v, 100);
        reg_read(2'd1, v); check("R10 reload readback", v, 100);
        reg_write(2'd0, C_EN | C_SRC);
        repeat (5) @(negedge clk);
        reg_read(2'd2, v); check("R1 counts when enabled", v, 95);

        // R6 debug halt freezes
        dbg_halt = 1'b1;
        reg_read(2'd2, v);
        repeat (10) @(negedge clk);
        reg_read(2'd2, v2); check("R6 halt freezes count", v2, v);
        dbg_halt = 1'b0;

        // R2 flag with irq disabled, R9 clear on read
        reg_write(2'd0, 32'h0);
        reg_write(2'd1, 32'd3);
        reg_write(2'd2, 32'h0);
        reg_write(2'd0, C_EN | C_SRC);
        irq_hits = 0;
        for (int i = 0; i < 12; i++) begin
            if (irq) irq_hits++;
            @(negedge clk);
        end
        check("R2 no irq when irq disabled", irq_hits, 0);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, v); check("R2 flag set after event", v, 32'h10000);
        reg_read(2'd0, v); check("R9 flag cleared by read", v, 0);

        // R4 current write reloads and clears flag
        reg_write(2'd0, C_EN | C_SRC);
        repeat (12) @(negedge clk);
        reg_write(2'd0, 32'h0);
        reg_write(2'd2, 32'hABCDEF);
        reg_read(2'd2, v); check("R4 write forces reload", v, 3);
        reg_read(2'd0, v); check("R4 write clears flag", v, 0);

        // R7 software pend
        sw_pend = 1'b1;
        @(negedge clk);
        sw_pend = 1'b0;
        check("R7 pend raises irq", irq, 1);
        @(negedge clk);
        check("R7 pend irq one cycle", irq, 0);

        // R8 zero reload stays quiet
        reg_write(2'd1, 32'h0);
        reg_write(2'd2, 32'h0);
        reg_write(2'd0, C_EN | C_IE | C_SRC);
        irq_hits = 0;
        for (int i = 0; i < 20; i++) begin
            if (irq) irq_hits++;
            @(negedge clk);
        end
        check("R8 no irq at zero reload", irq_hits, 0);
        reg_write(2'd0, 32'h0);
        reg_read(2'd2, v); check("R8 count stays zero", v, 0);
        reg_read(2'd0, v); check("R8 no flag at zero reload", v, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule